// File: doc/BRIEF.md
# Register-Cached Hardware Data Stack

This block is the operand stack of a zero-operand processor. The two topmost entries are held in dedicated registers (`tos` and `nos`), and every deeper entry is held in a small single-ported on-chip RAM. The execute stage issues one command per cycle: push a value, duplicate the top or second entry, drop, replace the top, or fold in an ALU result that consumes both top entries.

Because `tos` and `nos` drive the block's outputs directly from registers, the ALU can read its operands with no operand-fetch cycle. A result written by one command is the implicit input of the next command, so no forwarding path is needed.

At most one entry crosses between the registers and the RAM in any cycle. A push spills the old second entry into the RAM, and a pop refills the second register from the RAM. This is why one RAM port is enough. The block also reports the stack depth and keeps sticky flags for overflow and underflow.

Top module: `regcache_stack`

## Requirements
- R1: After reset, `depth` is 0, `tos` and `nos` are 0, and `overflow` and `underflow` are 0.
- R2: Command PUSH (code 1) makes `tos` equal `cmd_data` and `nos` equal the old `tos`, and increments `depth`. The old `nos` moves into the RAM when `depth` was 2 or more. The result is visible on the cycle after the command.
- R3: Command DUP (code 2) pushes a copy of `tos`, and needs depth ≥ 1. Command OVER (code 3) pushes a copy of `nos`, and needs depth ≥ 2. After DUP, `nos` equals the old `tos`, and the same holds after OVER.
- R4: Command BINOP (code 5) needs depth ≥ 2. It loads `alu_res` into `tos`, refills `nos` with the entry below, and decrements `depth`, all in the same cycle.
- R5: Command DROP (code 4) needs depth ≥ 1. It moves `nos` into `tos`, refills `nos` with the entry below, and decrements `depth`.
- R6: Command REPLACE (code 6) needs depth ≥ 1. It loads `cmd_data` into `tos` and leaves `nos` and `depth` unchanged.
- R7: The stack is last-in first-out over a capacity of RAM_DEPTH+2 entries. An unoccupied `tos` or `nos` reads 0.
- R8: A push-class command (PUSH, DUP, OVER) issued at depth RAM_DEPTH+2 changes no state. It sets `overflow`, which stays set until reset.
- R9: A command issued with fewer entries than it needs changes no state. It sets `underflow`, which stays set until reset.
- R10: Codes 0 (idle) and 7 (reserved) change no state.
- R11: The RAM is never both written and read in the same cycle, and `depth` changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 3 | Command code for this cycle |
| cmd_data | input | DATA_W | Value used by PUSH and REPLACE |
| alu_res | input | DATA_W | Result from the external ALU, used by BINOP |
| tos | output | DATA_W | Top entry of the stack |
| nos | output | DATA_W | Second entry of the stack |
| depth | output | $clog2(RAM_DEPTH+3) | Number of valid entries |
| overflow | output | 1 | Sticky overflow flag |
| underflow | output | 1 | Sticky underflow flag |

## Verification
Two things can happen in the same cycle. A BINOP writes the ALU result into `tos` and also refills `nos` from the RAM. A PUSH loads `tos` and also spills `nos` into the RAM. A small RAM is used so that both paths are hit again and again at every depth, including the two-entry boundary where no RAM access occurs. A long command stream that mixes all the command codes is compared, cycle by cycle, against an array model in the bench. That model reproduces the refill value, the result value and the zero-fill of empty registers. It also checks that both sticky flags stay clear until the first illegal command.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_PUSH  = 3'd1,
    OP_DUP   = 3'd2,
    OP_OVER  = 3'd3,
    OP_DROP  = 3'd4,
    OP_BINOP = 3'd5,
    OP_REPL  = 3'd6,
    OP_RSVD  = 3'd7
  } rcs_op_e;

  // Entries that must be present before the command can run.
  function automatic int unsigned op_needs(rcs_op_e op);
    case (op)
      OP_DUP, OP_DROP, OP_REPL: return 1;
      OP_OVER, OP_BINOP:        return 2;
      default:                  return 0;
    endcase
  endfunction

  function automatic logic op_grows(rcs_op_e op);
    return (op == OP_PUSH) || (op == OP_DUP) || (op == OP_OVER);
  endfunction

  function automatic logic op_shrinks(rcs_op_e op);
    return (op == OP_DROP) || (op == OP_BINOP);
  endfunction

endpackage

// File: rtl/rcs_ctrl.sv
module rcs_ctrl
  import rcs_pkg::*;
#(
  parameter int RAM_DEPTH = 16,
  parameter int DW        = $clog2(RAM_DEPTH + 3),
  parameter int AW        = $clog2(RAM_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rcs_op_e       op,
  output logic [DW-1:0] depth,
  output logic          ovf_flag,
  output logic          udf_flag,
  output logic          accept,
  output logic          ovf_evt,
  output logic          udf_evt,
  output logic          spill,
  output logic          fill,
  output logic [AW-1:0] ram_addr
);
  localparam int CAP = RAM_DEPTH + 2;

  logic          grows;
  logic          shrinks;
  logic [DW-1:0] slot;

  always_comb begin
    grows    = op_grows(op);
    shrinks  = op_shrinks(op);
    udf_evt  = (32'(depth) < op_needs(op));
    ovf_evt  = grows && (depth == DW'(CAP));
    accept   = !udf_evt && !ovf_evt;
    spill    = accept && grows && (depth >= DW'(2));
    fill     = accept && shrinks && (depth >= DW'(3));
    slot     = depth - (spill ? DW'(2) : DW'(3));
    ram_addr = (spill || fill) ? slot[AW-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth    <= '0;
      ovf_flag <= 1'b0;
      udf_flag <= 1'b0;
    end else begin
      if (accept && grows)
        depth <= depth + DW'(1);
      else if (accept && shrinks)
        depth <= depth - DW'(1);
      if (ovf_evt) ovf_flag <= 1'b1;
      if (udf_evt) udf_flag <= 1'b1;
    end
  end

endmodule

// File: rtl/rcs_ram.sv
module rcs_ram #(
  parameter int DATA_W    = 16,
  parameter int RAM_DEPTH = 16,
  parameter int AW        = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [RAM_DEPTH];

  for (genvar i = 0; i < RAM_DEPTH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (we && (32'(addr) == i))
        mem[i] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/rcs_regs.sv
module rcs_regs
  import rcs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rcs_op_e           op,
  input  logic              accept,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              fill,
  input  logic [DATA_W-1:0] fill_data,
  output logic [DATA_W-1:0] tos,
  output logic [DATA_W-1:0] nos
);
  logic [DATA_W-1:0] tos_d;
  logic [DATA_W-1:0] nos_d;
  logic [DATA_W-1:0] below;

  always_comb begin
    below = fill ? fill_data : '0;
    tos_d = tos;
    nos_d = nos;
    if (accept) begin
      case (op)
        OP_PUSH:  begin tos_d = cmd_data; nos_d = tos;   end
        OP_DUP:   begin tos_d = tos;      nos_d = tos;   end
        OP_OVER:  begin tos_d = nos;      nos_d = tos;   end
        OP_DROP:  begin tos_d = nos;      nos_d = below; end
        OP_BINOP: begin tos_d = alu_res;  nos_d = below; end
        OP_REPL:  begin tos_d = cmd_data;                end
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tos <= '0;
      nos <= '0;
    end else begin
      tos <= tos_d;
      nos <= nos_d;
    end
  end

endmodule

// File: rtl/regcache_stack.sv
module regcache_stack
  import rcs_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int RAM_DEPTH = 16,
  localparam int DW       = $clog2(RAM_DEPTH + 3),
  localparam int AW       = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [DATA_W-1:0] alu_res,
  output logic [DATA_W-1:0] tos,
  output logic [DATA_W-1:0] nos,
  output logic [DW-1:0]     depth,
  output logic              overflow,
  output logic              underflow
);
  rcs_op_e           op;
  logic              accept;
  logic              ovf_evt;
  logic              udf_evt;
  logic              ram_we;
  logic              ram_re;
  logic [AW-1:0]     ram_addr;
  logic [DATA_W-1:0] ram_rdata;

  assign op = rcs_op_e'(cmd);

  rcs_ctrl #(.RAM_DEPTH(RAM_DEPTH), .DW(DW), .AW(AW)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .depth    (depth),
    .ovf_flag (overflow),
    .udf_flag (underflow),
    .accept   (accept),
    .ovf_evt  (ovf_evt),
    .udf_evt  (udf_evt),
    .spill    (ram_we),
    .fill     (ram_re),
    .ram_addr (ram_addr)
  );

  rcs_ram #(.DATA_W(DATA_W), .RAM_DEPTH(RAM_DEPTH), .AW(AW)) ram_i (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (nos),
    .rdata (ram_rdata)
  );

  rcs_regs #(.DATA_W(DATA_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .accept    (accept),
    .cmd_data  (cmd_data),
    .alu_res   (alu_res),
    .fill      (ram_re),
    .fill_data (ram_rdata),
    .tos       (tos),
    .nos       (nos)
  );

endmodule

// File: rtl/regcache_stack_chk.sv
module regcache_stack_chk #(
  parameter int DATA_W    = 16,
  parameter int RAM_DEPTH = 16,
  parameter int DW        = $clog2(RAM_DEPTH + 3)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd,
  input logic [DATA_W-1:0] cmd_data,
  input logic [DATA_W-1:0] alu_res,
  input logic [DATA_W-1:0] tos,
  input logic [DATA_W-1:0] nos,
  input logic [DW-1:0]     depth,
  input logic              overflow,
  input logic              underflow,
  input logic              accept,
  input logic              ovf_evt,
  input logic              udf_evt,
  input logic              ram_we,
  input logic              ram_re
);
  localparam int CAP = RAM_DEPTH + 2;

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(depth) <= CAP); // R7

  AST_PUSH_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd1 && accept) |=> (tos == $past(cmd_data) && nos == $past(tos))); // R2

  AST_BINOP_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd5 && accept) |=> (tos == $past(alu_res))); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (depth == $past(depth) && tos == $past(tos) && nos == $past(nos) && overflow)); // R8

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    udf_evt |=> (depth == $past(depth) && tos == $past(tos) && nos == $past(nos) && underflow)); // R9

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow || underflow) |=> ((overflow || !$past(overflow)) && (underflow || !$past(underflow)))); // R8 R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd0 || cmd == 3'd7) |=> ($stable(tos) && $stable(nos) && $stable(depth))); // R10

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_re)); // R11

  AST_DEPTH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (depth == $past(depth) || depth == $past(depth) + DW'(1) || depth == $past(depth) - DW'(1))); // R11

endmodule

bind regcache_stack regcache_stack_chk #(
  .DATA_W(DATA_W), .RAM_DEPTH(RAM_DEPTH), .DW(DW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_data(cmd_data), .alu_res(alu_res),
  .tos(tos), .nos(nos), .depth(depth), .overflow(overflow), .underflow(underflow),
  .accept(accept), .ovf_evt(ovf_evt), .udf_evt(udf_evt),
  .ram_we(ram_we), .ram_re(ram_re)
);

// File: tb/regcache_stack_tb_top.sv
module regcache_stack_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 16;
  localparam int RD  = 4;
  localparam int CAP = RD + 2;
  localparam int DW  = $clog2(RD + 3);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    cmd = 3'd0;
  logic [W-1:0]  cmd_data = '0;
  logic [W-1:0]  alu_res = '0;
  logic [W-1:0]  tos, nos;
  logic [DW-1:0] depth;
  logic          overflow, underflow;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [W-1:0] m [CAP];
  int  md = 0;
  bit  movf = 0, mudf = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  regcache_stack #(.DATA_W(W), .RAM_DEPTH(RD)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_data(cmd_data), .alu_res(alu_res),
    .tos(tos), .nos(nos), .depth(depth), .overflow(overflow), .underflow(underflow)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int need_cnt(input int c);
    if (c == 2 || c == 4 || c == 6) return 1;
    if (c == 3 || c == 5) return 2;
    return 0;
  endfunction

  function automatic string tag_of(input int c, input bit ov, input bit ud);
    if (ov) return "R8";
    if (ud) return "R9";
    case (c)
      1: return "R2";
      2, 3: return "R3";
      4: return "R5";
      5: return "R4";
      6: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic compare_all(input string req);
    chk(req, "tos",       int'(tos),       (md >= 1) ? int'(m[md-1]) : 0);
    chk(req, "nos",       int'(nos),       (md >= 2) ? int'(m[md-2]) : 0);
    chk(req, "depth",     int'(depth),     md);
    chk(req, "overflow",  int'(overflow),  int'(movf));
    chk(req, "underflow", int'(underflow), int'(mudf));
  endtask

  task automatic step(input int c, input logic [W-1:0] d, input logic [W-1:0] a);
    bit grow, ov, ud;
    logic [W-1:0] t, n;
    cmd = 3'(c); cmd_data = d; alu_res = a;
    grow = (c == 1 || c == 2 || c == 3);
    ov = grow && (md == CAP);
    ud = md < need_cnt(c);
    t = (md >= 1) ? m[md-1] : '0;
    n = (md >= 2) ? m[md-2] : '0;
    @(posedge clk);
    #1;
    if (ov) movf = 1;
    else if (ud) mudf = 1;
    else begin
      case (c)
        1: begin m[md] = d; md++; end
        2: begin m[md] = t; md++; end
        3: begin m[md] = n; md++; end
        4: md--;
        5: begin md--; m[md-1] = a; end
        6: m[md-1] = d;
        default: ;
      endcase
    end
    compare_all(tag_of(c, ov, ud));
  endtask

  task automatic do_reset();
    rst_n = 0; cmd = 3'd0;
    md = 0; movf = 0; mudf = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1 compare_all("R1");
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R7: fill to capacity, each push spilling through the RAM
    for (int i = 0; i < CAP; i++) step(1, W'(16'h1100 + i), '0);
    // R8: push, DUP, OVER at full depth must be refused
    step(1, 16'hDEAD, '0);
    step(2, '0, '0);
    step(3, '0, '0);
    // R7: drain in LIFO order, each drop refilling from the RAM
    for (int i = 0; i < CAP; i++) step(4, '0, '0);
    // R9: commands needing entries on an empty or shallow stack
    step(4, '0, '0);
    step(6, 16'h0042, '0);
    step(1, 16'h0007, '0);
    step(5, '0, 16'h0099);
    step(3, '0, '0);
    step(2, '0, '0);
    step(3, '0, '0);
    // R4: result folding at every depth from full down to one
    do_reset();
    for (int i = 0; i < CAP; i++) step(1, W'(i * 3 + 1), '0);
    for (int i = 0; i < CAP - 1; i++) step(5, '0, W'(int'(tos) + int'(nos)));
    // R6 and R10
    step(6, 16'h5A5A, '0);
    step(0, 16'hFFFF, 16'hFFFF);
    step(7, 16'hFFFF, 16'hFFFF);
    // Mixed stream over all codes
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      lfsr = nxt(lfsr);
      step(int'(lfsr[2:0]), lfsr ^ 16'h3C3C, W'(int'(tos) * 3 + int'(nos)));
      if ((i % 1000) == 999) do_reset();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule